// File: doc/BRIEF.md
# Address-Masked GPIO Data Port

This block is an eight-pin general purpose I/O port that sits behind a simple word-addressed register bus. It holds one direction bit and one output data bit per pin. The data register is reached through a 256-word window, and the low bits of the word address act as a per-pin mask for both writes and reads. Software can therefore set, clear or sample a single pin, or any chosen group of pins, in one bus access. No read-modify-write sequence is needed, and no lock is needed between software threads that own different pins.

The bus port `bus_addr` carries a word address, so byte offset = 4 × `bus_addr`. Word addresses 0x000 to 0x0FF form the data window, and word 0x100 (byte 0x400) is the direction register. Every access is sampled on a rising edge into a small access sequencer. The sequencer's state names the kind of access: `ACC_IDLE`, `ACC_DATA_WR`, `ACC_DIR_WR`, `ACC_DATA_RD`, `ACC_DIR_RD` or `ACC_VOID_RD`. The access takes effect on the next rising edge. The strobes seen at an edge alone pick the next state, from any state, in this order:
- write to the data window → `ACC_DATA_WR`
- write to the direction word → `ACC_DIR_WR`
- write to any other address → `ACC_IDLE`
- read of the data window → `ACC_DATA_RD`
- read of the direction word → `ACC_DIR_RD`
- read of any other address → `ACC_VOID_RD`
- no strobe → `ACC_IDLE`

Pad inputs pass through a two-stage synchroniser before any read can observe them.

Top module: `gpio_mask_port`

## Requirements
- R1: After reset, `pad_oe`, `pad_out` and `bus_rdata` are all zero, and a read of the direction word returns zero.
- R2: A write to word address 0x100 loads all eight direction bits from `bus_wdata`. A 1 makes the pin an output. `pad_oe` shows the new value after the second rising edge counted from the edge that samples the write. A read of word 0x100 returns the full direction value.
- R3: For a write to word address A < 0x100, mask bit n is A[n]. Only pins whose mask bit is 1 take the written bit. Every other output bit keeps its value.
- R4: A data write has no effect on pins whose direction bit is 0 when the write takes effect. If such a pin is switched to output later, it drives its earlier stored value.
- R5: A read of word address A < 0x100 returns 0 in every bit n where A[n] is 0. Each other bit returns the stored data bit if pin n is an output, and the synchronised pad level if pin n is an input.
- R6: A pad change sampled on the same edge as a read strobe is not seen by that read. A read strobe sampled on the next edge sees the change.
- R7: `pad_out[n]` always equals the stored data bit of pin n, and `pad_oe[n]` always equals direction bit n.
- R8: Writes to word addresses other than 0x000 to 0x100 change no state. Reads of those addresses return zero.
- R9: When `bus_wr` and `bus_rd` are both high in a cycle, the write is performed and the read is dropped, so `bus_rdata` keeps its value.
- R10: `bus_rdata` changes only as the result of a read; it holds between reads and across writes.
- R11: Accesses may be issued in consecutive cycles. An access sampled on edge k takes effect on edge k+1, and a read sampled on edge k+1 observes the effect of a write sampled on edge k.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 10 | Word address (byte offset / 4) |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe, one access per cycle |
| pad_in | input | 8 | Asynchronous pad levels |
| bus_rdata | output | 8 | Registered read data, held between reads |
| pad_out | output | 8 | Pad output values |
| pad_oe | output | 8 | Per-pin output enables |

## Verification
Two kinds of collision are provoked on purpose.

The first is a pad transition presented in the very cycle a read strobe is sampled, followed by a second read one cycle later. The first read must return the old level and the second must return the new one. This shows the read takes its value from the end of the synchroniser chain and not from the raw pad.

The second is a write and a read in the same cycle, and a direction write followed at once by a data write. These are judged by comparing `pad_oe`, `pad_out` and `bus_rdata` every cycle against a behavioural model that applies accesses in the order they were sampled.

// File: rtl/gpio_mask_pkg.sv
package gpio_mask_pkg;

    // Kind of access currently being carried out by the sequencer.
    typedef enum logic [2:0] {
        ACC_IDLE    = 3'd0,
        ACC_DATA_WR = 3'd1,
        ACC_DIR_WR  = 3'd2,
        ACC_DATA_RD = 3'd3,
        ACC_DIR_RD  = 3'd4,
        ACC_VOID_RD = 3'd5
    } acc_state_e;

endpackage

// File: rtl/gpio_pad_sync.sv
module gpio_pad_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[0] <= '0;
                else        stage_q[0] <= async_in;
            end
        end else begin : g_rest
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_acc_fsm.sv
module gpio_acc_fsm
    import gpio_mask_pkg::*;
#(
    parameter int WADDR_W = 10,
    parameter int PINS    = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [WADDR_W-1:0] bus_addr,
    input  logic [PINS-1:0]    bus_wdata,
    input  logic               bus_wr,
    input  logic               bus_rd,
    output acc_state_e         state_q,
    output logic [PINS-1:0]    acc_mask,
    output logic [PINS-1:0]    acc_wdata,
    output logic               data_we,
    output logic               dir_we
);

    // The data window occupies the words whose bits above the mask are zero;
    // the direction word sits right after it.
    localparam logic [WADDR_W-1:0] DIR_WORD = WADDR_W'(1) << PINS;

    logic       in_window;
    logic       is_dir;
    acc_state_e state_d;

    assign in_window = (bus_addr[WADDR_W-1:PINS] == '0);
    assign is_dir    = (bus_addr == DIR_WORD);

    // Next-state choice: a write wins over a read in the same cycle.
    always_comb begin
        state_d = ACC_IDLE;
        unique case ({bus_wr, bus_rd})
            2'b10, 2'b11: begin
                if (in_window)   state_d = ACC_DATA_WR;
                else if (is_dir) state_d = ACC_DIR_WR;
                else             state_d = ACC_IDLE;
            end
            2'b01: begin
                if (in_window)   state_d = ACC_DATA_RD;
                else if (is_dir) state_d = ACC_DIR_RD;
                else             state_d = ACC_VOID_RD;
            end
            default: state_d = ACC_IDLE;
        endcase
    end

    // State register and captured access fields.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ACC_IDLE;
            acc_mask  <= '0;
            acc_wdata <= '0;
        end else begin
            state_q   <= state_d;
            acc_mask  <= in_window ? bus_addr[PINS-1:0] : '0;
            acc_wdata <= bus_wdata;
        end
    end

    // Output decode of the current state.
    always_comb begin
        data_we = 1'b0;
        dir_we  = 1'b0;
        unique case (state_q)
            ACC_DATA_WR: data_we = 1'b1;
            ACC_DIR_WR:  dir_we  = 1'b1;
            ACC_IDLE, ACC_DATA_RD, ACC_DIR_RD, ACC_VOID_RD: ;
            default: ;
        endcase
    end

endmodule

// File: rtl/gpio_pin_regs.sv
module gpio_pin_regs #(
    parameter int PINS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            data_we,
    input  logic            dir_we,
    input  logic [PINS-1:0] acc_mask,
    input  logic [PINS-1:0] acc_wdata,
    output logic [PINS-1:0] dir_q,
    output logic [PINS-1:0] data_q
);

    for (genvar n = 0; n < PINS; n++) begin : g_pin
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      dir_q[n] <= 1'b0;
            else if (dir_we) dir_q[n] <= acc_wdata[n];
        end

        // A masked-in bit lands only on a pin already driving.
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                data_q[n] <= 1'b0;
            else if (data_we && acc_mask[n] && dir_q[n])
                data_q[n] <= acc_wdata[n];
        end
    end

endmodule

// File: rtl/gpio_read_path.sv
module gpio_read_path
    import gpio_mask_pkg::*;
#(
    parameter int PINS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  acc_state_e      state_q,
    input  logic [PINS-1:0] acc_mask,
    input  logic [PINS-1:0] dir_q,
    input  logic [PINS-1:0] data_q,
    input  logic [PINS-1:0] pin_sync,
    output logic [PINS-1:0] rdata_q
);

    logic [PINS-1:0] level;

    for (genvar n = 0; n < PINS; n++) begin : g_level
        assign level[n] = dir_q[n] ? data_q[n] : pin_sync[n];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else begin
            unique case (state_q)
                ACC_DATA_RD: rdata_q <= level & acc_mask;
                ACC_DIR_RD:  rdata_q <= dir_q;
                ACC_VOID_RD: rdata_q <= '0;
                ACC_IDLE, ACC_DATA_WR, ACC_DIR_WR: rdata_q <= rdata_q;
                default:     rdata_q <= rdata_q;
            endcase
        end
    end

endmodule

// File: rtl/gpio_mask_port.sv
module gpio_mask_port
    import gpio_mask_pkg::*;
#(
    parameter int WADDR_W     = 10,
    parameter int PINS        = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [WADDR_W-1:0] bus_addr,
    input  logic [PINS-1:0]    bus_wdata,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [PINS-1:0]    pad_in,
    output logic [PINS-1:0]    bus_rdata,
    output logic [PINS-1:0]    pad_out,
    output logic [PINS-1:0]    pad_oe
);

    acc_state_e      state_q;
    logic [PINS-1:0] acc_mask;
    logic [PINS-1:0] acc_wdata;
    logic            data_we;
    logic            dir_we;
    logic [PINS-1:0] dir_q;
    logic [PINS-1:0] data_q;
    logic [PINS-1:0] pin_sync;

    gpio_pad_sync #(.WIDTH(PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (pin_sync)
    );

    gpio_acc_fsm #(.WADDR_W(WADDR_W), .PINS(PINS)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .state_q   (state_q),
        .acc_mask  (acc_mask),
        .acc_wdata (acc_wdata),
        .data_we   (data_we),
        .dir_we    (dir_we)
    );

    gpio_pin_regs #(.PINS(PINS)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .data_we   (data_we),
        .dir_we    (dir_we),
        .acc_mask  (acc_mask),
        .acc_wdata (acc_wdata),
        .dir_q     (dir_q),
        .data_q    (data_q)
    );

    gpio_read_path #(.PINS(PINS)) u_read (
        .clk      (clk),
        .rst_n    (rst_n),
        .state_q  (state_q),
        .acc_mask (acc_mask),
        .dir_q    (dir_q),
        .data_q   (data_q),
        .pin_sync (pin_sync),
        .rdata_q  (bus_rdata)
    );

    assign pad_out = data_q;
    assign pad_oe  = dir_q;

endmodule

// File: rtl/gpio_mask_port_chk.sv
module gpio_mask_port_chk #(
    parameter int WADDR_W = 10,
    parameter int PINS    = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic [WADDR_W-1:0] bus_addr,
    input logic [PINS-1:0]    bus_wdata,
    input logic               bus_wr,
    input logic               bus_rd,
    input logic [PINS-1:0]    bus_rdata,
    input logic [PINS-1:0]    pad_out,
    input logic [PINS-1:0]    pad_oe
);

    logic win_hit;
    logic dir_hit;
    logic rd_alone;

    assign win_hit  = (bus_addr >> PINS) == '0;
    assign dir_hit  = bus_addr == (WADDR_W'(1) << PINS);
    assign rd_alone = bus_rd && !bus_wr;

    assert_dir_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && dir_hit) |=> ##1 (pad_oe == $past(bus_wdata, 2)));

    assert_dir_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_alone && dir_hit) |=> ##1 (bus_rdata == $past(pad_oe)));

    assert_masked_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && win_hit) |=> ##1
        (((pad_out ^ $past(pad_out)) & ~$past(bus_addr[PINS-1:0], 2)) == '0));

    assert_input_pin_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && win_hit) |=> ##1 (((pad_out ^ $past(pad_out)) & ~pad_oe) == '0));

    assert_masked_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_alone && win_hit) |=> ##1 ((bus_rdata & ~$past(bus_addr[PINS-1:0], 2)) == '0));

    assert_void_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !win_hit && !dir_hit) |=> ##1 ($stable(pad_out) && $stable(pad_oe)));

    assert_void_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_alone && !win_hit && !dir_hit) |=> ##1 (bus_rdata == '0));

    assert_wr_beats_rd_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_rd) |=> ##1 $stable(bus_rdata));

    assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_rd) |=> ##1 $stable(bus_rdata));

endmodule

bind gpio_mask_port gpio_mask_port_chk #(.WADDR_W(WADDR_W), .PINS(PINS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe)
);

// File: tb/gpio_mask_port_bench.sv
`timescale 1ns/1ps
module gpio_mask_port_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] pad_in = '0;
    logic [7:0] bus_rdata;
    logic [7:0] pad_out;
    logic [7:0] pad_oe;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2 clk = ~clk;

    gpio_mask_port u_gpio_mask_port (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .pad_in(pad_in),
        .bus_rdata(bus_rdata), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    // Behavioural reference: 0 none, 1 data write, 2 dir write,
    // 3 data read, 4 dir read, 5 unmapped read.
    int         m_kind;
    logic [7:0] m_mask, m_wd, m_dir, m_data, m_s1, m_s2, m_rd;
    logic [7:0] t_dir, t_data, t_rd;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_kind = 0; m_mask = 0; m_wd = 0; m_dir = 0; m_data = 0;
            m_s1 = 0; m_s2 = 0; m_rd = 0;
        end else begin
            t_dir = m_dir; t_data = m_data; t_rd = m_rd;
            case (m_kind)
                1: t_data = (m_data & ~(m_mask & m_dir)) | (m_wd & m_mask & m_dir);
                2: t_dir  = m_wd;
                3: t_rd   = m_mask & ((m_dir & m_data) | (~m_dir & m_s2));
                4: t_rd   = m_dir;
                5: t_rd   = 8'h00;
                default: ;
            endcase
            m_dir = t_dir; m_data = t_data; m_rd = t_rd;
            m_s2 = m_s1; m_s1 = pad_in;
            m_wd = bus_wdata;
            m_mask = (bus_addr < 10'd256) ? bus_addr[7:0] : 8'h00;
            if (bus_wr)
                m_kind = (bus_addr < 10'd256) ? 1 : (bus_addr == 10'd256) ? 2 : 0;
            else if (bus_rd)
                m_kind = (bus_addr < 10'd256) ? 3 : (bus_addr == 10'd256) ? 4 : 5;
            else
                m_kind = 0;
        end
    end

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Every-cycle model comparison (R7 pin mapping, R11 timing).
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R7 model pad_out", pad_out, m_data);
            chk("R7 model pad_oe", pad_oe, m_dir);
            chk("R11 model rdata", bus_rdata, m_rd);
        end
    end

    task automatic bus_write(input logic [9:0] a, input logic [7:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1; bus_rd = 0;
        @(negedge clk); bus_wr = 0;
        @(negedge clk);
    endtask

    task automatic bus_read(input logic [9:0] a);
        @(negedge clk); bus_addr = a; bus_rd = 1; bus_wr = 0;
        @(negedge clk); bus_rd = 0;
        @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1 pad_oe", pad_oe, 8'h00);
        chk("R1 pad_out", pad_out, 8'h00);
        chk("R1 rdata", bus_rdata, 8'h00);
        bus_read(10'h100);
        chk("R1 dir read", bus_rdata, 8'h00);

        // Writes to input pins are dropped.
        bus_write(10'h0FF, 8'hFF);
        chk("R4 input write", pad_out, 8'h00);
        bus_write(10'h100, 8'h0F);
        chk("R2 pad_oe", pad_oe, 8'h0F);
        chk("R4 old value after switch", pad_out, 8'h00);
        bus_read(10'h100);
        chk("R2 dir read", bus_rdata, 8'h0F);

        // Masked writes.
        bus_write(10'h005, 8'hFF);
        chk("R3 mask 05", pad_out, 8'h05);
        bus_write(10'h0FF, 8'h00);
        chk("R3 mask FF clear", pad_out, 8'h00);
        bus_write(10'h002, 8'h02);
        chk("R3 single pin", pad_out, 8'h02);
        bus_write(10'h0C1, 8'hFF);
        chk("R4 mixed mask", pad_out, 8'h03);

        // Masked reads.
        pad_in = 8'hA0;
        repeat (3) @(negedge clk);
        bus_read(10'h0F0);
        chk("R5 inputs only", bus_rdata, 8'hA0);
        bus_read(10'h00F);
        chk("R5 outputs only", bus_rdata, 8'h03);
        bus_read(10'h000);
        chk("R5 empty mask", bus_rdata, 8'h00);
        bus_read(10'h0FF);
        chk("R5 full mask", bus_rdata, 8'hA3);
        repeat (3) @(negedge clk);
        chk("R10 hold idle", bus_rdata, 8'hA3);
        bus_write(10'h001, 8'h00);
        chk("R10 hold across write", bus_rdata, 8'hA3);
        chk("R3 clear pin0", pad_out, 8'h02);

        // Pad change in the same cycle as a read strobe.
        @(negedge clk); pad_in = 8'h10; bus_addr = 10'h0F0; bus_rd = 1;
        @(negedge clk);
        @(negedge clk); bus_rd = 0;
        chk("R6 same-edge read old", bus_rdata, 8'hA0);
        @(negedge clk);
        chk("R6 next-edge read new", bus_rdata, 8'h10);

        // Unmapped addresses.
        bus_write(10'h101, 8'hFF);
        bus_write(10'h3FF, 8'hFF);
        chk("R8 void write oe", pad_oe, 8'h0F);
        chk("R8 void write out", pad_out, 8'h02);
        bus_read(10'h200);
        chk("R8 void read", bus_rdata, 8'h00);

        // Write and read together.
        bus_read(10'h100);
        chk("R2 dir read again", bus_rdata, 8'h0F);
        @(negedge clk); bus_addr = 10'h100; bus_wdata = 8'hFF; bus_wr = 1; bus_rd = 1;
        @(negedge clk); bus_wr = 0; bus_rd = 0;
        @(negedge clk);
        chk("R9 write done", pad_oe, 8'hFF);
        chk("R9 read dropped", bus_rdata, 8'h0F);

        // Back-to-back write then read.
        @(negedge clk); bus_addr = 10'h0FF; bus_wdata = 8'h5A; bus_wr = 1;
        @(negedge clk); bus_wr = 0; bus_rd = 1;
        chk("R11 not yet applied", pad_out, 8'h02);
        @(negedge clk); bus_rd = 0;
        chk("R11 write applied", pad_out, 8'h5A);
        @(negedge clk);
        chk("R11 read sees write", bus_rdata, 8'h5A);

        // Direction cleared, then data write in the next cycle.
        @(negedge clk); bus_addr = 10'h100; bus_wdata = 8'h00; bus_wr = 1;
        @(negedge clk); bus_addr = 10'h0FF; bus_wdata = 8'hFF;
        @(negedge clk); bus_wr = 0;
        @(negedge clk);
        chk("R4 dir then data", pad_out, 8'h5A);
        chk("R2 dir cleared", pad_oe, 8'h00);
        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule